// File: doc/BRIEF.md
# Receive PAUSE Frame Classifier

This block sits on the receive path of an Ethernet MAC, after preamble and start-of-frame delimiter removal, and inspects each incoming frame byte by byte. It decides whether the frame is a MAC control frame and, if so, whether it is a PAUSE request that the local station must honour. For a recognised PAUSE it also extracts the 16-bit pause time in quanta.

The stream is one byte wide, qualified by a valid strobe, with start-of-frame and end-of-frame markers on the first and last bytes. Configuration inputs select full-duplex operation, enable receive flow control, allow PAUSE frames addressed to the station's own unicast address, and give that 48-bit address. The verdict appears as a one-cycle pulse in the cycle after the last byte of the frame is accepted. A throttling unit downstream uses the verdict. CRC checking and general address filtering happen elsewhere.

Top module: `pause_detect`

## Requirements
- R1: While reset is asserted and after its release, before any frame ends, ctrl_frame_o, pause_o and pause_quanta_o are all zero.
- R2: ctrl_frame_o pulses for a frame whose bytes 12 and 13 (0-based from the first destination byte, most significant byte first) form 0x8808. A frame that ends before byte 13 is not a control frame.
- R3: pause_o requires a control frame whose bytes 14 and 15 form opcode 0x0001 and that reaches at least byte 17. Otherwise the frame is at most a generic control frame.
- R4: pause_o requires full_duplex_i and rx_fc_en_i both high, sampled with the end-of-frame byte. If either is low, a qualifying frame gives ctrl_frame_o only.
- R5: A destination in bytes 0 to 5 equal to 01 80 C2 00 00 01, in that order, qualifies for PAUSE whatever ucast_pause_en_i is.
- R6: A destination equal to station_addr_i, with byte 0 taken from bits 47:40 down to byte 5 from bits 7:0, qualifies only when ucast_pause_en_i is high. Any other destination never qualifies.
- R7: pause_quanta_o equals bytes 16 and 17 (most significant byte first) when pause_o pulses, and is zero in every other cycle.
- R8: The outputs are registered. They pulse for exactly one cycle, the cycle after the end-of-frame byte is accepted, and are zero otherwise.
- R9: A start-of-frame byte begins a new frame at byte 0 and discards all state of an unfinished frame.
- R10: Cycles with rx_valid_i low are ignored, so gaps inside a frame do not change the result. Bytes that arrive outside a frame (no start-of-frame seen since the last end-of-frame or reset) are ignored, including their end-of-frame marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Receive byte |
| full_duplex_i | input | 1 | Link operates full duplex |
| rx_fc_en_i | input | 1 | Receive flow control enable |
| ucast_pause_en_i | input | 1 | Accept PAUSE to station address |
| station_addr_i | input | 48 | Station MAC address, first octet in bits 47:40 |
| ctrl_frame_o | output | 1 | Frame was a MAC control frame |
| pause_o | output | 1 | Frame was a valid PAUSE |
| pause_quanta_o | output | 16 | Pause time of the PAUSE frame |

## Verification
The assertions assume that configuration inputs are stable while the end-of-frame byte is accepted. They also assume that a control frame is at least 14 accepted bytes long, so two verdict pulses can never be adjacent. The bench changes configuration only between frames. Its frames come from a builder that places destination, type, opcode and pause time at fixed byte positions. Idle and gap cycles drive rx_valid_i low, so no stray byte can be accepted, and short-frame cases use explicit end-of-frame bytes.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam logic [47:0] PAUSE_MCAST  = 48'h0180_C200_0001;
  localparam logic [15:0] TYPE_MAC_CTL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE    = 16'h0001;
endpackage

// File: rtl/pd_frame_track.sv
module pd_frame_track #(
  parameter int unsigned SAT_IDX = 18,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             take_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] SAT = IDX_W'(SAT_IDX);

  logic             in_frame_q;
  logic [IDX_W-1:0] cnt_q;

  assign take_o = valid_i && (sof_i || in_frame_q);
  assign idx_o  = sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (take_o) begin
      in_frame_q <= !eof_i;
      cnt_q      <= (idx_o >= SAT) ? SAT : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/pd_addr_match.sv
module pd_addr_match #(
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               sof_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         data_i,
  input  logic [8*N_BYTES-1:0] ref_i,
  output logic               hit_o
);
  logic               hit_q;
  logic [N_BYTES-1:0] eq_vec;

  // byte 0 is the most significant octet of ref_i
  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    assign eq_vec[i] = (idx_i != IDX_W'(i)) ||
                       (data_i == ref_i[8*(N_BYTES-1-i) +: 8]);
  end

  always_comb begin
    hit_o = hit_q;
    if (take_i) hit_o = (sof_i ? 1'b1 : hit_q) & (&eq_vec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_o;
  end
endmodule

// File: rtl/pd_field_cap.sv
module pd_field_cap #(
  parameter int unsigned POS   = 12,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             sof_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [15:0]      field_o
);
  localparam logic [IDX_W-1:0] P_HI = IDX_W'(POS);
  localparam logic [IDX_W-1:0] P_LO = IDX_W'(POS + 1);

  logic [15:0] field_q;

  always_comb begin
    field_o = field_q;
    if (take_i) begin
      if (sof_i) field_o = '0;
      if (idx_i == P_HI) field_o[15:8] = data_i;
      if (idx_i == P_LO) field_o[7:0]  = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= '0;
    else         field_q <= field_o;
  end
endmodule

// File: rtl/pause_detect.sv
module pause_detect #(
  parameter int unsigned TYPE_POS = 12,
  parameter int unsigned OPC_POS  = 14,
  parameter int unsigned TIME_POS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic [7:0]  rx_data_i,
  input  logic        full_duplex_i,
  input  logic        rx_fc_en_i,
  input  logic        ucast_pause_en_i,
  input  logic [47:0] station_addr_i,
  output logic        ctrl_frame_o,
  output logic        pause_o,
  output logic [15:0] pause_quanta_o
);
  import pd_pkg::*;

  localparam int unsigned LAST_POS = TIME_POS + 1;
  localparam int unsigned SAT_IDX  = LAST_POS + 1;
  localparam int unsigned IDX_W    = $clog2(SAT_IDX + 1);
  localparam logic [IDX_W-1:0] TYPE_END = IDX_W'(TYPE_POS + 1);
  localparam logic [IDX_W-1:0] FULL_END = IDX_W'(LAST_POS);

  logic             take;
  logic [IDX_W-1:0] idx;
  logic             mc_hit, uc_hit;
  logic [15:0]      type_f, opc_f, time_f;
  logic             is_ctrl, is_pause;

  pd_frame_track #(.SAT_IDX(SAT_IDX), .IDX_W(IDX_W)) u_track (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i),
    .take_o(take), .idx_o(idx)
  );

  pd_addr_match #(.N_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_mc (
    .clk_i, .rst_ni, .take_i(take), .sof_i(rx_sof_i), .idx_i(idx),
    .data_i(rx_data_i), .ref_i(PAUSE_MCAST), .hit_o(mc_hit)
  );

  pd_addr_match #(.N_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_uc (
    .clk_i, .rst_ni, .take_i(take), .sof_i(rx_sof_i), .idx_i(idx),
    .data_i(rx_data_i), .ref_i(station_addr_i), .hit_o(uc_hit)
  );

  pd_field_cap #(.POS(TYPE_POS), .IDX_W(IDX_W)) u_type (
    .clk_i, .rst_ni, .take_i(take), .sof_i(rx_sof_i), .idx_i(idx),
    .data_i(rx_data_i), .field_o(type_f)
  );

  pd_field_cap #(.POS(OPC_POS), .IDX_W(IDX_W)) u_opc (
    .clk_i, .rst_ni, .take_i(take), .sof_i(rx_sof_i), .idx_i(idx),
    .data_i(rx_data_i), .field_o(opc_f)
  );

  pd_field_cap #(.POS(TIME_POS), .IDX_W(IDX_W)) u_time (
    .clk_i, .rst_ni, .take_i(take), .sof_i(rx_sof_i), .idx_i(idx),
    .data_i(rx_data_i), .field_o(time_f)
  );

  // classification uses field values including the end-of-frame byte
  assign is_ctrl  = (idx >= TYPE_END) && (type_f == TYPE_MAC_CTL);
  assign is_pause = is_ctrl && (idx >= FULL_END) && (opc_f == OPC_PAUSE) &&
                    full_duplex_i && rx_fc_en_i &&
                    (mc_hit || (ucast_pause_en_i && uc_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_frame_o   <= 1'b0;
      pause_o        <= 1'b0;
      pause_quanta_o <= '0;
    end else if (take && rx_eof_i) begin
      ctrl_frame_o   <= is_ctrl;
      pause_o        <= is_pause;
      pause_quanta_o <= is_pause ? time_f : '0;
    end else begin
      ctrl_frame_o   <= 1'b0;
      pause_o        <= 1'b0;
      pause_quanta_o <= '0;
    end
  end
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic        rx_eof_i,
  input logic        full_duplex_i,
  input logic        rx_fc_en_i,
  input logic        ctrl_frame_o,
  input logic        pause_o,
  input logic [15:0] pause_quanta_o
);
  p_pause_is_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> ctrl_frame_o);

  p_pause_needs_cfg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> $past(full_duplex_i && rx_fc_en_i));

  p_quanta_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_o |-> (pause_quanta_o == 16'h0));

  p_after_eof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_frame_o |-> $past(rx_valid_i && rx_eof_i));

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_frame_o |=> !ctrl_frame_o);
endmodule

bind pause_detect pd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_eof_i(rx_eof_i),
  .full_duplex_i(full_duplex_i), .rx_fc_en_i(rx_fc_en_i),
  .ctrl_frame_o(ctrl_frame_o), .pause_o(pause_o), .pause_quanta_o(pause_quanta_o)
);

// File: tb/tb_pause_detect.sv
module tb_pause_detect;
  localparam logic [47:0] STA = 48'h0211_2233_4455;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  dat = '0;
  logic        fd = 1'b0, fc = 1'b0, uc = 1'b0;
  logic        ctrl, paus;
  logic [15:0] quanta;

  int n_chk = 0, n_bad = 0;
  logic [7:0] frm [0:31];

  always #10 clk = ~clk;

  pause_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(vld), .rx_sof_i(sof),
    .rx_eof_i(eof), .rx_data_i(dat), .full_duplex_i(fd), .rx_fc_en_i(fc),
    .ucast_pause_en_i(uc), .station_addr_i(STA),
    .ctrl_frame_o(ctrl), .pause_o(paus), .pause_quanta_o(quanta)
  );

  task automatic chk(input logic c, input logic p, input logic [15:0] q,
                     input string req);
    n_chk++;
    if (ctrl !== c || paus !== p || quanta !== q) begin
      n_bad++;
      $display("FAIL %s: got ctrl=%0b pause=%0b q=%h, exp ctrl=%0b pause=%0b q=%h",
               req, ctrl, paus, quanta, c, p, q);
    end
  endtask

  // dk: 0 pause multicast, 1 station, 2 other unicast
  task automatic build(input int dk, input bit tok, input bit ook,
                       input logic [15:0] q);
    logic [47:0] da;
    da = (dk == 0) ? 48'h0180_C200_0001 : (dk == 1) ? STA : 48'h0211_2233_4456;
    for (int i = 0; i < 32; i++) frm[i] = 8'(8'h40 + i);
    for (int i = 0; i < 6; i++) frm[i] = da[8*(5-i) +: 8];
    frm[12] = tok ? 8'h88 : 8'h08;  frm[13] = tok ? 8'h08 : 8'h00;
    frm[14] = 8'h00;                frm[15] = ook ? 8'h01 : 8'h02;
    frm[16] = q[15:8];              frm[17] = q[7:0];
  endtask

  // drives at negedge; returns at the negedge after the last accepted byte
  task automatic send(input int len, input bit gaps, input bit with_eof);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        vld = 1'b0; dat = 8'hFF; eof = 1'b1;
        @(posedge clk); @(negedge clk);
      end
      vld = 1'b1; sof = (i == 0); eof = with_eof && (i == len - 1); dat = frm[i];
      @(posedge clk); @(negedge clk);
    end
    vld = 1'b0; sof = 1'b0; eof = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    @(posedge clk); @(negedge clk);
    chk(1'b0, 1'b0, 16'h0, req);
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ec, ep;
    logic [15:0] q;
    repeat (3) @(negedge clk);
    chk(1'b0, 1'b0, 16'h0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, 1'b0, 16'h0, "R1 after reset");

    // R10: bytes outside any frame, with end marker, are ignored
    build(0, 1, 1, 16'h1234);
    for (int i = 0; i < 18; i++) begin
      vld = 1'b1; eof = (i == 17); dat = frm[i];
      @(posedge clk); @(negedge clk);
    end
    vld = 1'b0; eof = 1'b0;
    chk(1'b0, 1'b0, 16'h0, "R10 out of frame");

    // full sweep over config, destination, type and opcode (R2..R8)
    for (int cfg = 0; cfg < 8; cfg++) begin
      fd = cfg[0]; fc = cfg[1]; uc = cfg[2];
      for (int dk = 0; dk < 3; dk++)
        for (int t = 0; t < 2; t++)
          for (int o = 0; o < 2; o++) begin
            q = 16'(cfg * 16'h1111 + dk * 16'h0301 + t * 16'h0050 + o + 1);
            build(dk, t[0], o[0], q);
            send(20 + (cfg % 3), (dk == 1), 1'b1);
            ec = t[0];
            ep = ec && o[0] && fd && fc && (dk == 0 || (dk == 1 && uc));
            chk(ec, ep, ep ? q : 16'h0, "R2 R3 R4 R5 R6 R7 sweep");
            idle_chk("R8 one-cycle pulse");
          end
    end

    // length sweep: R2 needs byte 13, R3 needs byte 17
    fd = 1'b1; fc = 1'b1; uc = 1'b0;
    for (int len = 1; len <= 24; len++) begin
      build(0, 1, 1, 16'hBEEF);
      send(len, (len % 2 == 0), 1'b1);
      ec = (len >= 14);
      ep = (len >= 18);
      chk(ec, ep, ep ? 16'hBEEF : 16'h0, "R2 R3 length");
      idle_chk("R8 pulse end");
    end

    // R9: unfinished pause frame then a plain frame
    build(0, 1, 1, 16'h0101);
    send(17, 1'b0, 1'b0);
    chk(1'b0, 1'b0, 16'h0, "R9 no eof");
    build(2, 0, 0, 16'h0);
    send(20, 1'b0, 1'b1);
    chk(1'b0, 1'b0, 16'h0, "R9 restart discards");
    idle_chk("R8");
    // R9: unfinished plain frame then pause frame
    build(2, 0, 0, 16'h0);
    send(15, 1'b0, 1'b0);
    build(0, 1, 1, 16'h7A5C);
    send(18, 1'b1, 1'b1);
    chk(1'b1, 1'b1, 16'h7A5C, "R9 restart detects");
    idle_chk("R8");

    // R10: gap cycles carrying junk do not alter result
    uc = 1'b1;
    build(1, 1, 1, 16'hFFFF);
    send(19, 1'b1, 1'b1);
    chk(1'b1, 1'b1, 16'hFFFF, "R10 gaps R6 station");
    idle_chk("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule